// File: doc/BRIEF.md
# Two-Wire Slave Front End for an Eight-Channel Sampling Converter

This block is the serial control side of an eight-channel, eight-bit sampling converter. It watches a two-wire serial bus (clock line and data line), oversampled by the system clock, and answers as a slave at a seven-bit address. Five bits of that address are fixed and two are set by strap pins. A write transfer carries a command byte that selects the input channel, the input pairing and the power mode. Receiving the channel field starts a conversion. A read transfer returns the eight-bit result, most significant bit first.

The bus lines are open-drain. The block never drives a line high: it has one pull-low enable for the data line and one for the clock line, and the wired-AND happens outside. A master code sent after a START puts the block into its high-speed state. That state survives a repeated START and ends at STOP. In that state a read that arrives before the conversion has finished is held off by keeping the clock line low until the result is ready. The analog core is replaced by a stub that captures an input value on the start pulse and publishes it a parameterised number of cycles later.

Top module: `adc_i2c_frontend`

## Requirements
- R1: An address byte is acknowledged (data line pulled low for the ninth clock) only when its bits 7..3 equal 10010 and its bits 2..1 equal the captured strap pins. Bit 0 selects the direction: 1 is read and 0 is write. Any other address gets no acknowledge.
- R2: The strap pins are sampled only while reset is asserted. A later change on `addr_pin_i` does not change the address the block answers to.
- R3: Every command byte that follows an acknowledged write address is acknowledged. `conv_sel_o` takes command bits 7..4 (bit 7 is the single-ended/differential flag, bits 6..4 the channel). `pwr_sel_o` takes bits 3..2 once the byte is acknowledged. Bits 1..0 have no effect.
- R4: `conv_start_o` is a one-cycle pulse. It is raised while the fourth command bit (bit 4) is being received, before bit 3 is clocked in.
- R5: A read returns, MSB first in straight binary, the value of `sample_i` that was captured on the most recent conversion start.
- R6: A read issued before any command has been received is acknowledged, returns 0x00 and starts no conversion.
- R7: START (data falls while clock is high) and STOP (data rises while clock is high) are recognised at any time. A repeated START in the middle of a byte discards the partial byte and restarts address reception. The block changes its data-line pull only while the clock line is low.
- R8: An address byte of the form 00001xxx is not acknowledged and sets `hs_mode_o`. `hs_mode_o` stays set across a repeated START and clears on STOP.
- R9: With `hs_mode_o` set, if the conversion is still running when the read-address acknowledge clock ends, the clock line is held low until the result is ready. The block never holds the clock line outside the high-speed state.
- R10: In the normal-speed state the clock line is never held, and the read returns the most recently completed result.
- R11: After each data byte, an acknowledge from the master (data low) makes the block send the result again. A not-acknowledge makes it release the data line so the master can issue STOP.
- R12: During and after reset, with an idle bus, both pull enables are low, `hs_mode_o` is low and no start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; strap pins are sampled while it is high |
| scl_i | input | 1 | Clock line level as seen on the wire |
| sda_i | input | 1 | Data line level as seen on the wire |
| addr_pin_i | input | 2 | Strap pins giving address bits 2..1 |
| sample_i | input | 8 | Value the converter stub captures on a start pulse |
| scl_pull_o | output | 1 | Pull the clock line low (stretching) |
| sda_pull_o | output | 1 | Pull the data line low (acknowledge or data zero) |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| conv_sel_o | output | 4 | Pairing flag and channel number from the command |
| pwr_sel_o | output | 2 | Power-mode field from the last acknowledged command |
| hs_mode_o | output | 1 | High-speed state flag |

## Verification
The assertions assume a master that keeps the data line steady while the clock line is high, except when it deliberately signals START or STOP. They also assume it never signals either condition while the block is pulling a line low, and holds every bus level for several system clocks so the synchronisers see each phase. The bench master keeps every half bit period at six system clocks or more. It changes its data line only in the low phase, after a short gap following the clock fall. It waits for the wired clock line to rise before timing the high phase, so a stretched clock never looks like a glitch.

// File: rtl/adci2c_pkg.sv
package adci2c_pkg;

    localparam int BYTE_W   = 8;
    localparam int SEL_BITS = 4;
    localparam int PWR_BITS = 2;

    localparam logic [4:0] DEV_ID  = 5'b10010;
    localparam logic [4:0] HS_CODE = 5'b00001;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_ACK,
        S_HOLD,
        S_TX,
        S_MACK,
        S_SKIP
    } link_state_t;

    typedef enum logic {
        GO_CMD,
        GO_TX
    } ack_next_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [1:0] pins);
        return (b[7:3] == DEV_ID) && (b[2:1] == pins);
    endfunction

    function automatic logic is_hs_code(input logic [BYTE_W-1:0] b);
        return b[7:3] == HS_CODE;
    endfunction

endpackage

// File: rtl/adci2c_bus_sync.sv
module adci2c_bus_sync
    import adci2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_q;
        ev_o.scl_fall = ~scl_s & scl_q;
        ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/adci2c_conv_stub.sv
module adci2c_conv_stub
    import adci2c_pkg::*;
#(
    parameter int LATENCY = 300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] sample_i,
    output logic              busy_o,
    output logic [BYTE_W-1:0] data_o
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            held   <= '0;
            busy_o <= 1'b0;
            data_o <= '0;
        end else if (start_i) begin
            cnt    <= CW'(LATENCY);
            held   <= sample_i;
            busy_o <= 1'b1;
        end else if (busy_o) begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
                busy_o <= 1'b0;
                data_o <= held;
            end
        end
    end
endmodule

// File: rtl/adci2c_link_ctrl.sv
module adci2c_link_ctrl
    import adci2c_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bus_ev_t             ev_i,
    input  logic [1:0]          pins_i,
    input  logic                conv_busy_i,
    input  logic [BYTE_W-1:0]   conv_data_i,
    output logic                sda_pull_o,
    output logic                scl_pull_o,
    output logic                conv_start_o,
    output logic [SEL_BITS-1:0] sel_o,
    output logic [PWR_BITS-1:0] pwr_o,
    output logic                hs_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    link_state_t       state;
    ack_next_t         nxt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        pins_q;
    logic              mack_q;

    // strap pins are only taken while reset is held
    always_ff @(posedge clk) begin
        if (rst) pins_q <= pins_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            nxt          <= GO_CMD;
            sh           <= '0;
            tx_sh        <= '0;
            cnt          <= '0;
            mack_q       <= 1'b1;
            conv_start_o <= 1'b0;
            sel_o        <= '0;
            pwr_o        <= '0;
            hs_o         <= 1'b0;
        end else begin
            conv_start_o <= 1'b0;
            if (ev_i.stop) begin
                state <= S_IDLE;
                hs_o  <= 1'b0;
            end else if (ev_i.start) begin
                state <= S_ADDR;
                cnt   <= '0;
            end else begin
                case (state)
                    S_ADDR, S_CMD: begin
                        if (ev_i.scl_rise && cnt < CNT_W'(BYTE_W)) begin
                            sh  <= {sh[BYTE_W-2:0], ev_i.sda};
                            cnt <= cnt + CNT_W'(1);
                            if (state == S_CMD && cnt == CNT_W'(SEL_BITS - 1)) begin
                                conv_start_o <= 1'b1;
                                sel_o        <= {sh[SEL_BITS-2:0], ev_i.sda};
                            end
                        end else if (ev_i.scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            if (state == S_CMD) begin
                                pwr_o <= sh[3:2];
                                nxt   <= GO_CMD;
                                state <= S_ACK;
                            end else if (addr_hit(sh, pins_q)) begin
                                nxt   <= sh[0] ? GO_TX : GO_CMD;
                                state <= S_ACK;
                            end else begin
                                if (is_hs_code(sh)) hs_o <= 1'b1;
                                state <= S_SKIP;
                            end
                        end
                    end
                    S_ACK: begin
                        if (ev_i.scl_fall) begin
                            cnt <= '0;
                            if (nxt == GO_TX) begin
                                if (hs_o && conv_busy_i) begin
                                    state <= S_HOLD;
                                end else begin
                                    tx_sh <= conv_data_i;
                                    state <= S_TX;
                                end
                            end else begin
                                state <= S_CMD;
                            end
                        end
                    end
                    S_HOLD: begin
                        if (!conv_busy_i) begin
                            tx_sh <= conv_data_i;
                            cnt   <= '0;
                            state <= S_TX;
                        end
                    end
                    S_TX: begin
                        if (ev_i.scl_fall) begin
                            if (cnt == CNT_W'(BYTE_W - 1)) begin
                                state <= S_MACK;
                            end else begin
                                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                                cnt   <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    S_MACK: begin
                        if (ev_i.scl_rise) begin
                            mack_q <= ev_i.sda;
                        end else if (ev_i.scl_fall) begin
                            if (mack_q) begin
                                state <= S_SKIP;
                            end else begin
                                tx_sh <= conv_data_i;
                                cnt   <= '0;
                                state <= S_TX;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_o = (state == S_ACK) | ((state == S_TX) & ~tx_sh[BYTE_W-1]);
    assign scl_pull_o = (state == S_HOLD);
endmodule

// File: rtl/adc_i2c_frontend.sv
module adc_i2c_frontend
    import adci2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CONV_LAT    = 300
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [1:0]          addr_pin_i,
    input  logic [BYTE_W-1:0]   sample_i,
    output logic                scl_pull_o,
    output logic                sda_pull_o,
    output logic                conv_start_o,
    output logic [SEL_BITS-1:0] conv_sel_o,
    output logic [PWR_BITS-1:0] pwr_sel_o,
    output logic                hs_mode_o
);
    bus_ev_t           bus_ev;
    logic              conv_busy;
    logic [BYTE_W-1:0] conv_data;

    adci2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (bus_ev)
    );

    adci2c_link_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ev_i         (bus_ev),
        .pins_i       (addr_pin_i),
        .conv_busy_i  (conv_busy),
        .conv_data_i  (conv_data),
        .sda_pull_o   (sda_pull_o),
        .scl_pull_o   (scl_pull_o),
        .conv_start_o (conv_start_o),
        .sel_o        (conv_sel_o),
        .pwr_o        (pwr_sel_o),
        .hs_o         (hs_mode_o)
    );

    adci2c_conv_stub #(.LATENCY(CONV_LAT)) u_conv (
        .clk      (clk),
        .rst      (rst),
        .start_i  (conv_start_o),
        .sample_i (sample_i),
        .busy_o   (conv_busy),
        .data_o   (conv_data)
    );
endmodule

// File: rtl/adci2c_checker.sv
module adci2c_checker
    import adci2c_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    scl_pull,
    input logic    sda_pull,
    input logic    hs_mode,
    input logic    conv_start,
    input logic    conv_busy,
    input bus_ev_t ev
);
    // R9: the clock line is only held in the high-speed state
    a_r9_hold_only_hs: assert property (@(posedge clk) disable iff (rst)
        scl_pull |-> hs_mode);

    // R9: holding ends only once the converter stub is no longer busy
    a_r9_hold_ends_ready: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_pull) |-> !conv_busy);

    // R9: never pull both lines at once
    a_r9_no_dual_pull: assert property (@(posedge clk) disable iff (rst)
        !(scl_pull && sda_pull));

    // R4: conversion start is a single-cycle pulse
    a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R8: the high-speed flag drops only after a STOP
    a_r8_hs_exit_on_stop: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_mode) |-> $past(ev.stop));

    // R7: data pull does not move while the clock line stays high
    a_r7_sda_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl)) |-> $stable(sda_pull));
endmodule

bind adc_i2c_frontend adci2c_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_pull   (scl_pull_o),
    .sda_pull   (sda_pull_o),
    .hs_mode    (hs_mode_o),
    .conv_start (conv_start_o),
    .conv_busy  (conv_busy),
    .ev         (bus_ev)
);

// File: tb/adc_i2c_frontend_bench.sv
`timescale 1ns/1ps
module adc_i2c_frontend_bench;

    localparam logic [4:0] DEV      = 5'b10010;
    localparam logic [1:0] DEV_PINS = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] pin_drive = DEV_PINS;
    logic [7:0] sample = 8'h00;

    logic       scl_line, sda_line;
    logic       scl_pull, sda_pull, conv_start, hs_mode;
    logic [3:0] conv_sel;
    logic [1:0] pwr_sel;

    always #4 clk = ~clk;

    assign scl_line = scl_m & ~scl_pull;
    assign sda_line = sda_m & ~sda_pull;

    adc_i2c_frontend u_adc_i2c_frontend (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_line),
        .sda_i        (sda_line),
        .addr_pin_i   (pin_drive),
        .sample_i     (sample),
        .scl_pull_o   (scl_pull),
        .sda_pull_o   (sda_pull),
        .conv_start_o (conv_start),
        .conv_sel_o   (conv_sel),
        .pwr_sel_o    (pwr_sel),
        .hs_mode_o    (hs_mode)
    );

    int checks = 0;
    int fails  = 0;
    int H      = 30;
    int cur_bit = 0;
    int hold_cyc = 0;
    int start_cnt = 0;
    int start_bit = -1;

    always @(posedge clk) begin
        if (scl_pull) hold_cyc <= hold_cyc + 1;
        if (conv_start) begin
            start_cnt <= start_cnt + 1;
            start_bit <= cur_bit;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; tick(H);
        scl_m = 1'b1; cur_bit++;
        while (!scl_line) tick(1);
        tick(H);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1;
        while (!scl_line) tick(1);
        tick(H / 2);
        b = sda_line;
        tick(H - H / 2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic put_byte(input logic [7:0] v, output bit ack);
        bit r;
        cur_bit = 0;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(r);
        ack = !r;
    endtask

    task automatic get_byte(output logic [7:0] v, input bit nack);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            get_bit(r);
            v[i] = r;
        end
        put_bit(nack);
    endtask

    // expected fields of a command byte
    function automatic logic [3:0] exp_sel(input logic [7:0] c);
        return c[7:4];
    endfunction
    function automatic logic [1:0] exp_pwr(input logic [7:0] c);
        return c[3:2];
    endfunction

    task automatic run_conv(input bit hs, input logic [7:0] cmd, input logic [7:0] smp);
        bit a;
        logic [7:0] d;
        int h0, s0;
        sample = smp;
        H = 30;
        bus_start();
        if (hs) begin
            put_byte({5'b00001, 3'($urandom)}, a);
            check(!a, "R8 master code not acknowledged", a, 0);
            check(hs_mode == 1'b1, "R8 high-speed set", hs_mode, 1);
            H = 6;
            bus_rstart();
        end
        h0 = hold_cyc;
        s0 = start_cnt;
        put_byte({DEV, DEV_PINS, 1'b0}, a);
        check(a, "R1 write address acknowledged", a, 1);
        put_byte(cmd, a);
        check(a, "R3 command acknowledged", a, 1);
        check(start_cnt == s0 + 1, "R4 one start pulse", start_cnt - s0, 1);
        check(start_bit == 4, "R4 start during bit 4", start_bit, 4);
        check(conv_sel == exp_sel(cmd), "R3 channel select", conv_sel, exp_sel(cmd));
        check(pwr_sel == exp_pwr(cmd), "R3 power field", pwr_sel, exp_pwr(cmd));
        bus_rstart();
        if (hs) check(hs_mode == 1'b1, "R8 kept over repeated START", hs_mode, 1);
        put_byte({DEV, DEV_PINS, 1'b1}, a);
        check(a, "R1 read address acknowledged", a, 1);
        get_byte(d, 1'b1);
        check(d == smp, "R5 conversion data", d, smp);
        if (hs) check(hold_cyc > h0, "R9 clock held in high-speed", hold_cyc - h0, 1);
        else    check(hold_cyc == h0, "R10 no clock hold", hold_cyc - h0, 0);
        check(sda_line == 1'b1, "R11 data line released after nack", sda_line, 1);
        bus_stop();
        tick(4);
        check(hs_mode == 1'b0, "R8 STOP leaves high-speed", hs_mode, 0);
    endtask

    task automatic run_all();
        bit a;
        logic [7:0] d;
        void'($urandom(32'd5171));
        rst = 1'b1; tick(6); rst = 1'b0; tick(3);

        // R12 reset state
        check(sda_pull == 1'b0, "R12 data pull idle", sda_pull, 0);
        check(scl_pull == 1'b0, "R12 clock pull idle", scl_pull, 0);
        check(hs_mode == 1'b0, "R12 high-speed clear", hs_mode, 0);
        check(start_cnt == 0, "R12 no start pulse", start_cnt, 0);

        // R6 read before any command
        bus_start();
        put_byte({DEV, DEV_PINS, 1'b1}, a);
        check(a, "R6 early read acknowledged", a, 1);
        get_byte(d, 1'b1);
        check(d == 8'h00, "R6 early read data", d, 0);
        check(start_cnt == 0, "R6 no conversion started", start_cnt, 0);
        bus_stop();

        // R1 address mismatches
        bus_start();
        put_byte({5'b10011, DEV_PINS, 1'b0}, a);
        check(!a, "R1 fixed part mismatch", a, 0);
        bus_stop();
        bus_start();
        put_byte({DEV, 2'b11, 1'b0}, a);
        check(!a, "R1 pin bits mismatch", a, 0);
        bus_stop();

        // R2 pins only sampled during reset
        pin_drive = 2'b01;
        tick(5);
        bus_start();
        put_byte({DEV, 2'b01, 1'b0}, a);
        check(!a, "R2 new pin value ignored", a, 0);
        bus_stop();
        bus_start();
        put_byte({DEV, DEV_PINS, 1'b0}, a);
        check(a, "R2 reset pin value kept", a, 1);
        bus_stop();

        // R7 repeated START inside a byte
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
        bus_rstart();
        put_byte({DEV, DEV_PINS, 1'b0}, a);
        check(a, "R7 address after mid-byte restart", a, 1);
        bus_stop();

        // directed conversions
        run_conv(1'b0, 8'hA7, 8'h5C);
        run_conv(1'b1, 8'h3C, 8'hC3);
        run_conv(1'b0, 8'h00, 8'hFF);
        run_conv(1'b1, 8'hFF, 8'h00);

        // R11 master acknowledge repeats the byte
        H = 30;
        bus_start();
        put_byte({DEV, DEV_PINS, 1'b1}, a);
        get_byte(d, 1'b0);
        check(d == 8'h00, "R11 first byte", d, 0);
        sample = 8'h99;
        get_byte(d, 1'b1);
        check(d == 8'h00, "R11 repeated byte", d, 0);
        check(sda_line == 1'b1, "R11 released after nack", sda_line, 1);
        bus_stop();

        // random transactions
        for (int k = 0; k < 14; k++) begin
            run_conv(1'($urandom), 8'($urandom), 8'($urandom));
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                tick(150000);
                checks++;
                fails++;
                $display("FAIL watchdog expired actual=0x0 expected=0x1");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule